// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the host bus and the erase/program controller of an embedded flash macro. It watches word writes (an address and a 16-bit data word) and recognises the multi-write command sequences that start a full-array erase, a single-block erase or a word program, or that switch reads over to the protection status. It also recognises the single-write commands that suspend, resume or abandon an erase. Each accepted command produces a one-cycle pulse towards the controller. The block keeps an operating mode, and that mode decides what a read returns: array data, the status register or the protection status.

Every write first passes a step tracker that holds the position inside a multi-write sequence and reports at most one decoded command per write. A mode controller then accepts or discards that command according to the current mode: reading the array, erasing, erase suspended, or protection read. It also registers the pulses. A small read selector turns the mode and the read address into a source code. Only bits 7:0 of the data word carry the command code. The command addresses are compared on bits 13:0 of the address. The block number is the top `BLK_W` address bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A full-array erase is the unlock pair (AAh at 1554h, then 55h at 2AA8h), then 80h at 1554h, the unlock pair again, then 10h at 1554h as the sixth write. `chip_erase_go` pulses in the cycle after the sixth write, and the mode becomes erasing.
- R2: The same five opening writes followed by 30h at any address start a block erase. `blk_erase_go` pulses, `erase_blk` takes the top `BLK_W` bits of that address, and the mode becomes erasing.
- R3: A write that does not match the next expected step, or an F0h in the middle of a sequence, drops the sequence and produces no pulse. This includes a sixth write that is neither confirm. A later write that would only be valid mid-sequence then has no effect.
- R4: While a block erase runs, B0h at any address pulses `susp_go` and the mode becomes suspended. During a full-array erase, B0h is ignored.
- R5: While erasing, every write other than B0h and F0h is ignored, and it leaves no partial sequence behind. At most one command pulse is high in any cycle.
- R6: 30h at any address pulses `resume_go` and returns the mode to erasing, but only while suspended. In any other mode it does nothing.
- R7: Word program is the unlock pair, A0h at 1554h, then a data write. `prog_go` pulses with `prog_addr`/`prog_data` set to that write. While suspended, the data write is accepted only if its block differs from `erase_blk`.
- R8: F0h while erasing pulses `abort_go`. F0h while suspended pulses both `abort_go` and `blk_invalid_go`. In every case the mode returns to array reading.
- R9: The protection preamble (5Ah at 2AA8h, then A5h at 1554h) followed by 90h at 2A54h selects protection reads. These stay selected until an F0h.
- R10: `rd_sel` is 0 for array data, 1 for the status register and 2 for protection status. It is 1 while erasing. While suspended, it is 1 only for a `rd_addr` inside `erase_blk` and 0 otherwise.
- R11: Bits 15:8 of the write data never affect command recognition.
- R12: After reset all pulses are low, `rd_sel` is 0 and `erase_blk` is 0. An `erase_done` pulse while erasing returns the mode to array reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data; low byte is the command code |
| erase_done | input | 1 | Controller reports the erase finished |
| rd_addr | input | ADDR_W | Current read address |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 protection |
| chip_erase_go | output | 1 | Start full-array erase |
| blk_erase_go | output | 1 | Start block erase |
| erase_blk | output | BLK_W | Block of the current or last erase |
| prog_go | output | 1 | Start word program |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | DATA_W | Program data |
| susp_go | output | 1 | Suspend the erase |
| resume_go | output | 1 | Resume the erase |
| abort_go | output | 1 | Abandon the erase |
| blk_invalid_go | output | 1 | Suspended block contents are now invalid |

## Verification
Each command pulse and each mode change is registered once. It is therefore visible in the cycle that follows the clock edge sampling the write, and it is gone one edge later. The bench drives each write on a falling edge and samples the pulses and `rd_sel` on the next falling edge, exactly one register stage after the write. `rd_sel` also depends combinationally on `rd_addr`, so changes of `rd_addr` are checked half a cycle after they are driven, with no edge in between. An `erase_done` pulse is checked on the falling edge after the edge that samples it.

// File: rtl/flash_cmd_pkg.sv
// Shared codes and types of the flash command decoder.
// Assumes command addresses are matched on the low CMD_AW bits only.
package flash_cmd_pkg;

    localparam int CMD_AW = 14;

    localparam logic [CMD_AW-1:0] ADR_KEY_A = 14'h1554;
    localparam logic [CMD_AW-1:0] ADR_KEY_B = 14'h2AA8;
    localparam logic [CMD_AW-1:0] ADR_PSTAT = 14'h2A54;

    localparam logic [7:0] C_UNLOCK1 = 8'hAA;
    localparam logic [7:0] C_UNLOCK2 = 8'h55;
    localparam logic [7:0] C_ERASE   = 8'h80;
    localparam logic [7:0] C_ALL     = 8'h10;
    localparam logic [7:0] C_CONFIRM = 8'h30;
    localparam logic [7:0] C_PROGRAM = 8'hA0;
    localparam logic [7:0] C_SUSPEND = 8'hB0;
    localparam logic [7:0] C_RESET   = 8'hF0;
    localparam logic [7:0] C_PKEY1   = 8'h5A;
    localparam logic [7:0] C_PKEY2   = 8'hA5;
    localparam logic [7:0] C_PREAD   = 8'h90;

    typedef enum logic [3:0] {
        ST_IDLE, ST_UNL1, ST_UNL2, ST_ERA, ST_ERA_UNL1, ST_ERA_UNL2,
        ST_PRG, ST_PEN1, ST_PEN2
    } seq_step_t;

    typedef enum logic [2:0] {
        EV_NONE, EV_CHIP, EV_BLOCK, EV_PROG, EV_PROTRD, EV_RESET, EV_SUSP, EV_RESUME
    } cmd_ev_t;

    typedef enum logic [1:0] {M_ARRAY, M_ERASE, M_SUSP, M_PROT} op_mode_t;

    typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_STATUS = 2'd1, RD_PROT = 2'd2} rd_src_t;

endpackage

// File: rtl/flash_seq_tracker.sv
// Tracks the position within multi-write command sequences and reports
// at most one decoded command per write. Assumes one write per cycle.
// While hold is high (erase running), only single-write codes decode and
// the step is kept at idle.
module flash_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold,
    output cmd_ev_t           ev
);

    seq_step_t   step, step_nxt;
    logic [7:0]  code;
    logic        at_a, at_b, at_ps;

    assign code  = wr_data[7:0];
    assign at_a  = (wr_addr[CMD_AW-1:0] == ADR_KEY_A);
    assign at_b  = (wr_addr[CMD_AW-1:0] == ADR_KEY_B);
    assign at_ps = (wr_addr[CMD_AW-1:0] == ADR_PSTAT);

    // Next step and decoded command for the current write.
    always_comb begin
        step_nxt = step;
        ev       = EV_NONE;
        if (hold) begin
            step_nxt = ST_IDLE;
            if (wr_en && code == C_RESET)        ev = EV_RESET;
            else if (wr_en && code == C_SUSPEND) ev = EV_SUSP;
        end else if (wr_en) begin
            if (step == ST_PRG) begin
                ev       = EV_PROG;
                step_nxt = ST_IDLE;
            end else if (code == C_RESET) begin
                ev       = EV_RESET;
                step_nxt = ST_IDLE;
            end else begin
                step_nxt = ST_IDLE;
                case (step)
                    ST_IDLE: begin
                        if (at_a && code == C_UNLOCK1)      step_nxt = ST_UNL1;
                        else if (at_b && code == C_PKEY1)   step_nxt = ST_PEN1;
                        else if (code == C_SUSPEND)         ev = EV_SUSP;
                        else if (code == C_CONFIRM)         ev = EV_RESUME;
                    end
                    ST_UNL1:     if (at_b && code == C_UNLOCK2) step_nxt = ST_UNL2;
                    ST_UNL2: begin
                        if (at_a && code == C_ERASE)        step_nxt = ST_ERA;
                        else if (at_a && code == C_PROGRAM) step_nxt = ST_PRG;
                    end
                    ST_ERA:      if (at_a && code == C_UNLOCK1) step_nxt = ST_ERA_UNL1;
                    ST_ERA_UNL1: if (at_b && code == C_UNLOCK2) step_nxt = ST_ERA_UNL2;
                    ST_ERA_UNL2: begin
                        if (at_a && code == C_ALL)          ev = EV_CHIP;
                        else if (code == C_CONFIRM)         ev = EV_BLOCK;
                    end
                    ST_PEN1:     if (at_a && code == C_PKEY2) step_nxt = ST_PEN2;
                    ST_PEN2:     if (at_ps && code == C_PREAD) ev = EV_PROTRD;
                    default:     step_nxt = ST_IDLE;
                endcase
            end
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_IDLE;
        else        step <= step_nxt;
    end

    // While an erase runs no partial sequence survives.
    p_hold_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (step == ST_IDLE));

endmodule

// File: rtl/flash_mode_ctrl.sv
// Holds the operating mode and turns accepted commands into one-cycle
// pulses for the erase/program controller. Assumes the controller reports
// completion with a one-cycle erase_done while erasing.
module flash_mode_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_ev_t           ev,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_done,
    output op_mode_t          mode,
    output logic [BLK_W-1:0]  erase_blk,
    output logic              chip_erase_go,
    output logic              blk_erase_go,
    output logic              prog_go,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              susp_go,
    output logic              resume_go,
    output logic              abort_go,
    output logic              blk_invalid_go
);

    logic [BLK_W-1:0] wr_blk;
    logic             is_chip;

    assign wr_blk = wr_addr[ADDR_W-1 -: BLK_W];

    // Mode transitions and registered command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode           <= M_ARRAY;
            erase_blk      <= '0;
            is_chip        <= 1'b0;
            chip_erase_go  <= 1'b0;
            blk_erase_go   <= 1'b0;
            prog_go        <= 1'b0;
            prog_addr      <= '0;
            prog_data      <= '0;
            susp_go        <= 1'b0;
            resume_go      <= 1'b0;
            abort_go       <= 1'b0;
            blk_invalid_go <= 1'b0;
        end else begin
            chip_erase_go  <= 1'b0;
            blk_erase_go   <= 1'b0;
            prog_go        <= 1'b0;
            susp_go        <= 1'b0;
            resume_go      <= 1'b0;
            abort_go       <= 1'b0;
            blk_invalid_go <= 1'b0;
            case (mode)
                M_ARRAY: begin
                    if (ev == EV_CHIP) begin
                        chip_erase_go <= 1'b1;
                        is_chip       <= 1'b1;
                        mode          <= M_ERASE;
                    end else if (ev == EV_BLOCK) begin
                        blk_erase_go  <= 1'b1;
                        erase_blk     <= wr_blk;
                        is_chip       <= 1'b0;
                        mode          <= M_ERASE;
                    end else if (ev == EV_PROG) begin
                        prog_go       <= 1'b1;
                        prog_addr     <= wr_addr;
                        prog_data     <= wr_data;
                    end else if (ev == EV_PROTRD) begin
                        mode          <= M_PROT;
                    end
                end
                M_ERASE: begin
                    if (ev == EV_RESET) begin
                        abort_go <= 1'b1;
                        mode     <= M_ARRAY;
                    end else if (ev == EV_SUSP && !is_chip) begin
                        susp_go  <= 1'b1;
                        mode     <= M_SUSP;
                    end else if (erase_done) begin
                        mode     <= M_ARRAY;
                    end
                end
                M_SUSP: begin
                    if (ev == EV_RESUME) begin
                        resume_go <= 1'b1;
                        mode      <= M_ERASE;
                    end else if (ev == EV_PROG && wr_blk != erase_blk) begin
                        prog_go   <= 1'b1;
                        prog_addr <= wr_addr;
                        prog_data <= wr_data;
                    end else if (ev == EV_RESET) begin
                        abort_go       <= 1'b1;
                        blk_invalid_go <= 1'b1;
                        mode           <= M_ARRAY;
                    end
                end
                default: begin
                    if (ev == EV_RESET) mode <= M_ARRAY;
                end
            endcase
        end
    end

    p_one_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chip_erase_go, blk_erase_go, prog_go, susp_go, resume_go, abort_go}));

    p_invalid_needs_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_invalid_go |-> (abort_go && $past(mode) == M_SUSP && mode == M_ARRAY));

    p_resume_from_susp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resume_go |-> ($past(mode) == M_SUSP));

    p_susp_only_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        susp_go |-> ($past(mode) == M_ERASE && !$past(is_chip)));

    p_prog_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go && $past(mode) == M_SUSP) |-> (prog_addr[ADDR_W-1 -: BLK_W] != erase_blk));

endmodule

// File: rtl/flash_rd_mux.sv
// Chooses the read source from the mode and the read address.
// Assumes the caller decodes the two-bit source code.
module flash_rd_mux
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 3
) (
    input  op_mode_t          mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BLK_W-1:0]  erase_blk,
    output logic [1:0]        rd_sel
);

    rd_src_t src;

    // Map mode (and, while suspended, the read block) to a source.
    always_comb begin
        case (mode)
            M_ERASE: src = RD_STATUS;
            M_PROT:  src = RD_PROT;
            M_SUSP:  src = (rd_addr[ADDR_W-1 -: BLK_W] == erase_blk) ? RD_STATUS : RD_ARRAY;
            default: src = RD_ARRAY;
        endcase
    end

    assign rd_sel = src;

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command interface: step tracker, mode controller and
// read selector. Assumes at most one bus write per cycle.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_sel,
    output logic              chip_erase_go,
    output logic              blk_erase_go,
    output logic [BLK_W-1:0]  erase_blk,
    output logic              prog_go,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              susp_go,
    output logic              resume_go,
    output logic              abort_go,
    output logic              blk_invalid_go
);

    cmd_ev_t  ev;
    op_mode_t mode;
    logic     hold;

    assign hold = (mode == M_ERASE);

    flash_seq_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hold(hold), .ev(ev)
    );

    flash_mode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .ev(ev), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_done(erase_done), .mode(mode), .erase_blk(erase_blk),
        .chip_erase_go(chip_erase_go), .blk_erase_go(blk_erase_go),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
        .susp_go(susp_go), .resume_go(resume_go), .abort_go(abort_go),
        .blk_invalid_go(blk_invalid_go)
    );

    flash_rd_mux #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_rd (
        .mode(mode), .rd_addr(rd_addr), .erase_blk(erase_blk), .rd_sel(rd_sel)
    );

    p_erase_reads_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_erase_go || blk_erase_go) |-> (rd_sel == 2'd1));

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int BLK_W  = 3;
    localparam int N_VEC  = 45;

    // {addr, data, pulses{chip,blk,prog,susp,resume,abort,invalid}, rd_sel}; rd_addr = 0
    localparam logic [40:0] VEC [N_VEC] = '{
        {16'h1554, 16'h00AA, 7'h00, 2'd0}, {16'h2AA8, 16'h0055, 7'h00, 2'd0},
        {16'h1554, 16'h0080, 7'h00, 2'd0}, {16'h1554, 16'h00AA, 7'h00, 2'd0},
        {16'h2AA8, 16'h0055, 7'h00, 2'd0}, {16'h1554, 16'h0010, 7'h40, 2'd1},
        {16'h0000, 16'h00B0, 7'h00, 2'd1}, {16'h0000, 16'h00F0, 7'h02, 2'd0},
        {16'h1554, 16'h00AA, 7'h00, 2'd0}, {16'h2AA8, 16'h0055, 7'h00, 2'd0},
        {16'h1554, 16'h0080, 7'h00, 2'd0}, {16'h1554, 16'h00AA, 7'h00, 2'd0},
        {16'h2AA8, 16'h0055, 7'h00, 2'd0}, {16'hA000, 16'h0030, 7'h20, 2'd1},
        {16'h1554, 16'h00AA, 7'h00, 2'd1}, {16'h1234, 16'h00B0, 7'h08, 2'd0},
        {16'h1554, 16'h00AA, 7'h00, 2'd0}, {16'h2AA8, 16'h0055, 7'h00, 2'd0},
        {16'h1554, 16'h00A0, 7'h00, 2'd0}, {16'h2010, 16'h1234, 7'h10, 2'd0},
        {16'h1554, 16'h00AA, 7'h00, 2'd0}, {16'h2AA8, 16'h0055, 7'h00, 2'd0},
        {16'h1554, 16'h00A0, 7'h00, 2'd0}, {16'hA004, 16'h5678, 7'h00, 2'd0},
        {16'h0000, 16'h0030, 7'h04, 2'd1}, {16'h0000, 16'h00B0, 7'h08, 2'd0},
        {16'h0000, 16'h00F0, 7'h03, 2'd0}, {16'h1554, 16'h00AA, 7'h00, 2'd0},
        {16'h2AA9, 16'h0055, 7'h00, 2'd0}, {16'h1554, 16'h0080, 7'h00, 2'd0},
        {16'h1554, 16'h00AA, 7'h00, 2'd0}, {16'h2AA8, 16'h0055, 7'h00, 2'd0},
        {16'h1554, 16'h0080, 7'h00, 2'd0}, {16'h1554, 16'h00AA, 7'h00, 2'd0},
        {16'h2AA8, 16'h0055, 7'h00, 2'd0}, {16'h1554, 16'h0020, 7'h00, 2'd0},
        {16'h2AA8, 16'h005A, 7'h00, 2'd0}, {16'h1554, 16'h00A5, 7'h00, 2'd0},
        {16'h2A54, 16'h0090, 7'h00, 2'd2}, {16'h1554, 16'h00AA, 7'h00, 2'd2},
        {16'h0000, 16'h00F0, 7'h00, 2'd0}, {16'h1554, 16'hFFAA, 7'h00, 2'd0},
        {16'h2AA8, 16'h1255, 7'h00, 2'd0}, {16'h1554, 16'h7BA0, 7'h00, 2'd0},
        {16'h0040, 16'hBEEF, 7'h10, 2'd0}
    };

    // Requirement touched by each table row (for messages).
    function automatic string row_req(int i);
        if (i < 8)       return "R1";
        else if (i < 14) return "R2";
        else if (i < 15) return "R5";
        else if (i < 16) return "R4";
        else if (i < 24) return "R7";
        else if (i < 25) return "R6";
        else if (i < 27) return "R8";
        else if (i < 36) return "R3";
        else if (i < 41) return "R9";
        else             return "R11";
    endfunction

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              erase_done = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [1:0]        rd_sel;
    logic              chip_erase_go, blk_erase_go, prog_go, susp_go;
    logic              resume_go, abort_go, blk_invalid_go;
    logic [BLK_W-1:0]  erase_blk;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] seen;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_done(erase_done), .rd_addr(rd_addr), .rd_sel(rd_sel),
        .chip_erase_go(chip_erase_go), .blk_erase_go(blk_erase_go), .erase_blk(erase_blk),
        .prog_go(prog_go), .prog_addr(prog_addr), .prog_data(prog_data),
        .susp_go(susp_go), .resume_go(resume_go), .abort_go(abort_go),
        .blk_invalid_go(blk_invalid_go)
    );

    function automatic logic [6:0] pulses();
        return {chip_erase_go, blk_erase_go, prog_go, susp_go, resume_go, abort_go, blk_invalid_go};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write: drive on a falling edge, sample one edge later.
    task automatic do_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        seen  = pulses();
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        do_wr(16'h1554, 16'h00AA);
        do_wr(16'h2AA8, 16'h0055);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(pulses() == 7'h00 && rd_sel == 2'd0 && erase_blk == '0, "R12",
              {21'd0, pulses(), rd_sel, erase_blk}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            do_wr(VEC[i][40:25], VEC[i][24:9]);
            check(seen == VEC[i][8:2], row_req(i), {25'd0, seen}, {25'd0, VEC[i][8:2]});
            check(rd_sel == VEC[i][1:0], "R10", {30'd0, rd_sel}, {30'd0, VEC[i][1:0]});
        end
        // R7/R11: program values of the last row
        check(prog_addr == 16'h0040 && prog_data == 16'hBEEF, "R7",
              {prog_addr, prog_data}, 32'h0040BEEF);

        // R2: block number of a block erase at 6000h
        unlock(); do_wr(16'h1554, 16'h0080); unlock(); do_wr(16'h6000, 16'h0030);
        check(erase_blk == 3'd3, "R2", {29'd0, erase_blk}, 32'd3);
        // R6: resume while erasing (not suspended) does nothing
        do_wr(16'h0000, 16'h0030);
        check(seen == 7'h00 && rd_sel == 2'd1, "R6", {23'd0, seen, rd_sel}, 32'd1);
        // R10: read mapping while suspended
        do_wr(16'h0000, 16'h00B0);
        @(negedge clk); rd_addr = 16'h7F00; #1;
        check(rd_sel == 2'd1, "R10", {30'd0, rd_sel}, 32'd1);
        rd_addr = 16'h8000; #1;
        check(rd_sel == 2'd0, "R10", {30'd0, rd_sel}, 32'd0);
        rd_addr = 16'h0000;
        // R12: erase_done ends the erase
        do_wr(16'h0000, 16'h0030);
        check(rd_sel == 2'd1, "R6", {30'd0, rd_sel}, 32'd1);
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        check(rd_sel == 2'd0, "R12", {30'd0, rd_sel}, 32'd0);

        // R3: F0 mid-sequence drops it; 80h afterwards starts nothing
        unlock(); do_wr(16'h0000, 16'h00F0); do_wr(16'h1554, 16'h0080);
        unlock(); do_wr(16'h1554, 16'h0010);
        check(seen == 7'h00 && rd_sel == 2'd0, "R3", {23'd0, seen, rd_sel}, 32'd0);

        // R8: reset from protection mode without pulses
        do_wr(16'h2AA8, 16'h005A); do_wr(16'h1554, 16'h00A5); do_wr(16'h2A54, 16'h0090);
        do_wr(16'h0000, 16'hABF0);
        check(seen == 7'h00 && rd_sel == 2'd0, "R8", {23'd0, seen, rd_sel}, 32'd0);

        // R12: reset during a full-array erase
        unlock(); do_wr(16'h1554, 16'h0080); unlock(); do_wr(16'h1554, 16'h0010);
        check(rd_sel == 2'd1, "R1", {30'd0, rd_sel}, 32'd1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(rd_sel == 2'd0 && pulses() == 7'h00, "R12", {23'd0, pulses(), rd_sel}, 32'd0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule